// File: doc/BRIEF.md
# DMA Channel Request Scheduler

This block chooses which DMA channel may move its next data element. Each channel presents a 32-bit configuration word and a remaining element count. The controller also supplies a global enable and a 32-bit vector of peripheral request lines, which is the OR of single and burst requests. The scheduler grants at most one channel at a time. It marks a channel whose flow type it cannot serve as unsupported.

A channel is eligible when it is enabled and not halted, and its count is nonzero. A 3-bit flow type in its configuration word says which peripheral request lines must be active. The grant is registered. Once a channel holds the grant, it keeps it for as long as it stays eligible. While the transfer engine reports busy, the grant is frozen. When the channel is released, the search resumes at the next higher index and wraps from the last channel back to channel 0.

Top module: `dma_chan_sched`

## Requirements
- R1: While `ctrl_en` is low, no new grant is made, and any held grant is dropped at the first edge where `busy` is low.
- R2: A channel is a candidate only if configuration bit 0 (enable) is 1 and bit 18 (halt) is 0.
- R3: The flow type is configuration bits [13:11], the source request index is bits [5:1] and the destination request index is bits [10:6]. Flow type 0 needs no request. Type 1 needs `periph_req[dest]`. Type 2 needs `periph_req[src]`. Type 3 needs both.
- R4: A channel whose remaining count is zero is never granted.
- R5: A channel with flow type 4 to 7 is never granted. `unsup[c]` is 1 whenever channel c has bit 0 set and a flow type of 4 or more.
- R6: After reset the search starts at channel 0 and picks the lowest eligible index. A granted channel keeps the grant for as long as it remains eligible.
- R7: When the granted channel is released, the search starts at the next index and wraps from NCH-1 to 0.
- R8: While `grant_valid` and `busy` are both high, the grant does not change. The next decision is taken at the first edge where `busy` is sampled low.
- R9: `grant_onehot` has at most one bit set. That bit is bit `grant_idx`, and it is set exactly when `grant_valid` is 1.
- R10: In reset `grant_valid` is 0 and `grant_onehot` is 0. Grant outputs change one clock edge after the inputs that decide them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Global controller enable |
| chan_cfg | input | 32*NCH | Configuration word of each channel; channel c at bits [32c+31:32c] |
| chan_cnt | input | CNT_W*NCH | Remaining element count of each channel |
| periph_req | input | 32 | Peripheral request lines (single OR burst) |
| busy | input | 1 | Granted channel has an element in flight |
| grant_valid | output | 1 | A channel holds the grant |
| grant_idx | output | IW | Index of the granted channel |
| grant_onehot | output | NCH | One-hot form of the grant |
| unsup | output | NCH | Channel is enabled with an unsupported flow type |

## Verification
Four behaviours are checked by assertions on every cycle. A held grant is frozen while busy is high. A granted channel was eligible on the edge that chose it. A disabled controller leaves no grant. The one-hot output agrees with the index and the valid flag. The bench scenarios cover what needs a sequence of stimulus. These are the ascending order after reset, resuming at the next index after a release, the wrap past the top channel, each flow type waiting for its own request line, and the unsupported flag.

// File: rtl/dma_chan_sched.sv
module dma_chan_sched #(
  parameter int NCH   = 8,
  parameter int CNT_W = 12,
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_en,
  input  logic [32*NCH-1:0]  chan_cfg,
  input  logic [CNT_W*NCH-1:0] chan_cnt,
  input  logic [31:0]        periph_req,
  input  logic               busy,
  output logic               grant_valid,
  output logic [IW-1:0]      grant_idx,
  output logic [NCH-1:0]     grant_onehot,
  output logic [NCH-1:0]     unsup
);

  logic [NCH-1:0] elig;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [31:0] cfg;
    logic [2:0]  flow;
    logic        src_ok, dst_ok, flow_ok, live;
    assign cfg     = chan_cfg[c*32 +: 32];
    assign flow    = cfg[13:11];
    assign src_ok  = periph_req[cfg[5:1]];
    assign dst_ok  = periph_req[cfg[10:6]];
    assign flow_ok = (flow == 3'd0) || (flow == 3'd1 && dst_ok) ||
                     (flow == 3'd2 && src_ok) || (flow == 3'd3 && src_ok && dst_ok);
    assign live    = cfg[0] && !cfg[18];
    assign unsup[c] = cfg[0] && flow[2];
    assign elig[c]  = ctrl_en && live && flow_ok && (chan_cnt[c*CNT_W +: CNT_W] != '0);
  end

  logic          gv;
  logic [IW-1:0] gi, ptr, gi_next, start;
  logic          pick_v;
  logic [IW-1:0] pick_i;

  assign gi_next = (int'(gi) == NCH-1) ? '0 : gi + 1'b1;
  assign start   = gv ? gi_next : ptr;

  always_comb begin
    int j;
    pick_v = 1'b0;
    pick_i = '0;
    for (int k = 0; k < NCH; k++) begin
      j = int'(start) + k;
      if (j >= NCH) j = j - NCH;
      if (!pick_v && elig[j]) begin
        pick_v = 1'b1;
        pick_i = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gv  <= 1'b0;
      gi  <= '0;
      ptr <= '0;
    end else if (gv && busy) begin
      gv <= gv;
    end else if (gv && elig[gi]) begin
      gv <= gv;
    end else begin
      gv <= pick_v;
      if (pick_v) gi <= pick_i;
      if (gv) ptr <= gi_next;
    end
  end

  assign grant_valid  = gv;
  assign grant_idx    = gi;
  assign grant_onehot = gv ? (NCH'(1) << gi) : '0;

  AST_OFF_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !(grant_valid && busy)) |=> !grant_valid); // R1
  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && busy) |=> (!grant_valid || ((($past(elig) >> grant_idx) & NCH'(1)) != '0))); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && busy) |=> (grant_valid && $stable(grant_idx))); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && elig[grant_idx]) |=> (grant_valid && $stable(grant_idx))); // R6
  AST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_onehot) && ((|grant_onehot) == grant_valid)); // R9

endmodule

// File: tb/tb_dma_chan_sched.sv
module tb_dma_chan_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int CNT_W = 12;
  localparam int IW = $clog2(NCH);

  logic clk = 0, rst_n = 0, ctrl_en = 0, busy = 0;
  logic [31:0] periph_req = '0;
  logic [31:0] cfg [NCH];
  logic [CNT_W-1:0] cnt [NCH];
  logic [32*NCH-1:0] chan_cfg;
  logic [CNT_W*NCH-1:0] chan_cnt;
  logic grant_valid;
  logic [IW-1:0] grant_idx;
  logic [NCH-1:0] grant_onehot, unsup;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++) begin
      chan_cfg[c*32 +: 32] = cfg[c];
      chan_cnt[c*CNT_W +: CNT_W] = cnt[c];
    end

  dma_chan_sched #(.NCH(NCH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .chan_cfg(chan_cfg),
    .chan_cnt(chan_cnt), .periph_req(periph_req), .busy(busy),
    .grant_valid(grant_valid), .grant_idx(grant_idx),
    .grant_onehot(grant_onehot), .unsup(unsup));

  function automatic logic [31:0] mk(bit en, bit halt, int flow, int src, int dst);
    logic [31:0] v = '0;
    v[0] = en; v[5:1] = src[4:0]; v[10:6] = dst[4:0]; v[13:11] = flow[2:0]; v[18] = halt;
    return v;
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0; ctrl_en = 1; busy = 0; periph_req = '0;
    for (int c = 0; c < NCH; c++) begin cfg[c] = '0; cnt[c] = '0; end
    tick(2);
    rst_n = 1;
  endtask

  task automatic check(string tag, bit ev, int ei);
    logic [NCH-1:0] eoh;
    eoh = ev ? (NCH'(1) << ei) : '0;
    checks++;
    if (grant_valid !== ev || (ev && grant_idx !== IW'(ei))) begin
      errors++;
      $display("FAIL %s: grant valid=%0b idx=%0d, expected valid=%0b idx=%0d",
               tag, grant_valid, grant_idx, ev, ei);
    end
    checks++;
    if (grant_onehot !== eoh) begin
      errors++;
      $display("FAIL R9 (%s): onehot=%b expected %b", tag, grant_onehot, eoh);
    end
  endtask

  task automatic check_unsup(string tag, logic [NCH-1:0] exp);
    checks++;
    if (unsup !== exp) begin
      errors++;
      $display("FAIL %s: unsup=%b expected %b", tag, unsup, exp);
    end
  endtask

  task automatic t_reset();
    do_reset();
    rst_n = 0;
    cfg[0] = mk(1,0,0,0,0); cnt[0] = 3;
    cfg[5] = mk(1,0,0,0,0); cnt[5] = 3;
    tick();
    check("R10 in reset", 0, 0);
    rst_n = 1;
    tick();
    check("R6 lowest index after reset", 1, 0);
  endtask

  task automatic t_enable();
    do_reset();
    ctrl_en = 0;
    cfg[3] = mk(1,0,0,0,0); cnt[3] = 4;
    tick(2);
    check("R1 disabled no grant", 0, 0);
    ctrl_en = 1;
    tick();
    check("R1 enabled grant", 1, 3);
    ctrl_en = 0;
    tick();
    check("R1 grant dropped", 0, 0);
  endtask

  task automatic t_halt();
    do_reset();
    cfg[1] = mk(1,1,0,0,0); cnt[1] = 2;
    cfg[2] = mk(0,0,0,0,0); cnt[2] = 2;
    cfg[4] = mk(1,0,0,0,0); cnt[4] = 2;
    tick();
    check("R2 halted and disabled skipped", 1, 4);
    cfg[1] = mk(1,0,0,0,0);
    cnt[4] = 0;
    tick();
    check("R2 unhalted channel picked after wrap", 1, 1);
  endtask

  task automatic t_flow();
    do_reset();
    cfg[2] = mk(1,0,1,0,7); cnt[2] = 5;
    tick();
    check("R3 type1 waits", 0, 0);
    periph_req[7] = 1;
    tick();
    check("R3 type1 dest req", 1, 2);
    do_reset();
    cfg[2] = mk(1,0,2,3,0); cnt[2] = 5;
    periph_req[7] = 1;
    tick();
    check("R3 type2 wrong line", 0, 0);
    periph_req[3] = 1;
    tick();
    check("R3 type2 src req", 1, 2);
    do_reset();
    cfg[2] = mk(1,0,3,4,9); cnt[2] = 5;
    periph_req[4] = 1;
    tick();
    check("R3 type3 src only", 0, 0);
    periph_req = '0; periph_req[9] = 1;
    tick();
    check("R3 type3 dest only", 0, 0);
    periph_req[4] = 1;
    tick();
    check("R3 type3 both", 1, 2);
  endtask

  task automatic t_zero();
    do_reset();
    cfg[0] = mk(1,0,0,0,0); cnt[0] = 0;
    cfg[1] = mk(1,0,0,0,0); cnt[1] = 1;
    tick();
    check("R4 zero count skipped", 1, 1);
    cnt[1] = 0;
    tick();
    check("R4 all zero", 0, 0);
  endtask

  task automatic t_unsup();
    do_reset();
    periph_req = '1;
    cfg[0] = mk(1,0,5,1,2); cnt[0] = 3;
    cfg[3] = mk(1,0,7,1,2); cnt[3] = 3;
    tick();
    check("R5 unsupported not granted", 0, 0);
    check_unsup("R5 flags", 8'b0000_1001);
  endtask

  task automatic t_order();
    do_reset();
    cfg[0] = mk(1,0,0,0,0); cnt[0] = 2;
    cfg[1] = mk(1,0,0,0,0); cnt[1] = 2;
    tick();
    check("R6 first grant", 1, 0);
    tick(3);
    check("R6 sticky while eligible", 1, 0);
    cnt[0] = 0;
    tick();
    check("R7 next index", 1, 1);
    do_reset();
    cfg[6] = mk(1,0,0,0,0); cnt[6] = 2;
    tick();
    check("R7 setup", 1, 6);
    cfg[7] = mk(1,0,0,0,0); cnt[7] = 2;
    cfg[2] = mk(1,0,0,0,0); cnt[2] = 2;
    tick();
    check("R6 held with others waiting", 1, 6);
    cnt[6] = 0;
    tick();
    check("R7 resume above released", 1, 7);
    cnt[7] = 0;
    tick();
    check("R7 wrap to low index", 1, 2);
  endtask

  task automatic t_busy();
    do_reset();
    cfg[0] = mk(1,0,0,0,0); cnt[0] = 2;
    cfg[1] = mk(1,0,0,0,0); cnt[1] = 2;
    tick();
    check("R8 setup", 1, 0);
    busy = 1; cnt[0] = 0;
    tick(2);
    check("R8 held while busy", 1, 0);
    busy = 0;
    tick();
    check("R8 decide after busy low", 1, 1);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin cfg[c] = '0; cnt[c] = '0; end
    t_reset();
    t_enable();
    t_halt();
    t_flow();
    t_zero();
    t_unsup();
    t_order();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule